// File: doc/BRIEF.md
# Presettable Synchronous Binary Up Counter

This block is a small binary up counter, four bits wide by default. Every state bit is a flip-flop on one rising clock edge, so all output bits change at the same moment and no ripple glitches appear between them. At each edge the block does one of four things: clear to zero, parallel-load a data word, advance by one, or hold. Clear and load are active-low and both act only at the clock edge. Clear wins over load, and load wins over counting.

Counting needs two enables to be high together. Only the second enable, the carry-side enable, gates the carry output. The carry output is high when the count is all ones and the carry-side enable is high. To build a wider counter, chain several instances on the same clock. Each stage's carry output drives the next stage's carry-side enable, and the count-side enable is shared by all stages. The chained counter then advances as one word and needs no extra gates.

Outside logic can shorten the count. It decodes the last wanted value and drives clear low from that decode, so the counter returns to zero on the following edge. The control pins are plain level inputs sampled at each edge. There is no data stream, so there is no handshake. The power-up count is undefined until the first clear or load.

Top module: `sync_bin_counter`

## Requirements
- R1: All count bits update together on the rising edge of `clk`; the bits never disagree with the value that the rules below give for that edge.
- R2: When `clear_n` is 0 at a rising edge, `count` becomes 0 after that edge, whatever `load_n`, `enable_p`, `enable_t` and `data_in` are.
- R3: When `clear_n` is 1 and `load_n` is 0 at a rising edge, `count` takes the value of `data_in` after that edge, for every combination of `enable_p` and `enable_t`.
- R4: When `clear_n` and `load_n` are both 1 and `enable_p` and `enable_t` are both 1 at a rising edge, `count` increases by one.
- R5: When `clear_n` and `load_n` are both 1 and at least one of `enable_p` or `enable_t` is 0 at a rising edge, `count` keeps its value.
- R6: When the count is all ones and a count step occurs, `count` wraps to 0 and `carry_out` falls.
- R7: `carry_out` is 1 exactly when `count` is all ones and `enable_t` is 1. It follows `enable_t` with no clock edge in between.
- R8: `enable_p` has no effect on `carry_out`.
- R9: Two instances form an 8-bit counter when they share `enable_p` and the low stage's `carry_out` drives the high stage's `enable_t`. The 8-bit value then steps through 0 to 255 and wraps to 0, and the high stage's `carry_out` is 1 only at 255.
- R10: When `clear_n` is driven from a decode of count value N, the counter repeats the sequence 0 to N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state bits |
| clear_n | input | 1 | Clear to zero at the edge, active low; highest priority |
| load_n | input | 1 | Take `data_in` at the edge, active low; overrides both enables |
| enable_p | input | 1 | Count-side enable; gates counting only |
| enable_t | input | 1 | Carry-side enable; gates counting and `carry_out` |
| data_in | input | WIDTH | Value loaded while `load_n` is low |
| count | output | WIDTH | Registered count |
| carry_out | output | 1 | High when `count` is all ones and `enable_t` is high |

## Verification
The bench loads every value with all four enable combinations. A design that let an enable block loading would hold or step instead of taking the data. From every value, the bench asserts clear together with load and both enables, to catch a design with the priority reversed, which would load or count. The bench sweeps the enables at the all-ones count to expose a carry wrongly gated by `enable_p`, and it counts through the wrap. A two-stage chain is run through all 256 values and a decode-driven modulo-10 sequence is checked. A lookahead prefix with a broken bit would then give a wrong high-byte step or an early return to zero.

// File: rtl/sync_bin_counter_pkg.sv
package sync_bin_counter_pkg;

  // Action taken at one clock edge, in priority order.
  typedef enum logic [1:0] {
    ACT_CLEAR = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_STEP  = 2'd2,
    ACT_KEEP  = 2'd3
  } act_e;

  function automatic act_e pick_action(input logic clr_n, input logic ld_n,
                                       input logic en_p, input logic en_t);
    if (!clr_n)             return ACT_CLEAR;
    else if (!ld_n)         return ACT_LOAD;
    else if (en_p && en_t)  return ACT_STEP;
    else                    return ACT_KEEP;
  endfunction

endpackage

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sync_bin_counter_pkg::*;
(
  input  logic clear_n,
  input  logic load_n,
  input  logic enable_p,
  input  logic enable_t,
  output act_e act
);

  always_comb begin
    act = pick_action(clear_n, load_n, enable_p, enable_t);
  end

endmodule

// File: rtl/sbc_lookahead.sv
module sbc_lookahead #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt,
  output logic             full
);

  // run[i] is high when all bits below i are one: bit i toggles then.
  logic [WIDTH:0] run;

  assign run[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign run[i+1] = run[i] & cur[i];
    assign nxt[i]   = cur[i] ^ run[i];
  end

  assign full = run[WIDTH];

endmodule

// File: rtl/sbc_state.sv
module sbc_state
  import sync_bin_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  act_e             act,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] step_val,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    case (act)
      ACT_CLEAR: q <= '0;
      ACT_LOAD:  q <= load_val;
      ACT_STEP:  q <= step_val;
      default:   q <= q;
    endcase
  end

endmodule

// File: rtl/sync_bin_counter.sv
module sync_bin_counter
  import sync_bin_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             enable_p,
  input  logic             enable_t,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  act_e             act;
  logic [WIDTH-1:0] step_val;
  logic             at_top;

  sbc_ctrl u_ctrl (
    .clear_n  (clear_n),
    .load_n   (load_n),
    .enable_p (enable_p),
    .enable_t (enable_t),
    .act      (act)
  );

  sbc_lookahead #(.WIDTH(WIDTH)) u_look (
    .cur  (count),
    .nxt  (step_val),
    .full (at_top)
  );

  sbc_state #(.WIDTH(WIDTH)) u_state (
    .clk      (clk),
    .act      (act),
    .load_val (data_in),
    .step_val (step_val),
    .q        (count)
  );

  assign carry_out = at_top & enable_t;

  // Checker state: the count is known once a clear or load has been taken.
  logic seeded_q = 1'b0;
  always_ff @(posedge clk) begin
    if (!clear_n || !load_n) seeded_q <= 1'b1;
  end

  // R2
  clear_wins_chk: assert property (@(posedge clk) disable iff (!seeded_q)
    !clear_n |=> (count == '0));

  // R3
  load_any_enable_chk: assert property (@(posedge clk) disable iff (!seeded_q)
    (clear_n && !load_n) |=> (count == $past(data_in)));

  // R4
  step_by_one_chk: assert property (@(posedge clk) disable iff (!seeded_q)
    (clear_n && load_n && enable_p && enable_t)
      |=> (count == WIDTH'($past(count) + 1'b1)));

  // R5
  hold_value_chk: assert property (@(posedge clk) disable iff (!seeded_q)
    (clear_n && load_n && !(enable_p && enable_t)) |=> $stable(count));

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!seeded_q)
    (clear_n && load_n && enable_p && enable_t && count == ALL_ONES)
      |=> (count == '0 && !carry_out));

  // R7
  carry_match_chk: assert property (@(posedge clk) disable iff (!seeded_q)
    carry_out == (count == ALL_ONES && enable_t));

endmodule

// File: tb/sync_bin_counter_bench.sv
module sync_bin_counter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clear_n = 1'b1, load_n = 1'b1, enable_p = 1'b0, enable_t = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] count;
  logic         carry_out;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_bin_counter #(.WIDTH(W)) u_sync_bin_counter (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .enable_p(enable_p),
    .enable_t(enable_t), .data_in(data_in), .count(count), .carry_out(carry_out)
  );

  // Two-stage chain for R9.
  logic         ch_clear_n = 1'b1, ch_en = 1'b0;
  logic [W-1:0] lo_q, hi_q;
  logic         lo_c, hi_c;

  sync_bin_counter #(.WIDTH(W)) u_lo (
    .clk(clk), .clear_n(ch_clear_n), .load_n(1'b1), .enable_p(ch_en),
    .enable_t(ch_en), .data_in('0), .count(lo_q), .carry_out(lo_c)
  );
  sync_bin_counter #(.WIDTH(W)) u_hi (
    .clk(clk), .clear_n(ch_clear_n), .load_n(1'b1), .enable_p(ch_en),
    .enable_t(lo_c), .data_in('0), .count(hi_q), .carry_out(hi_c)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int exp;
    #2;
    // Clear from unknown state
    clear_n = 1'b0; load_n = 1'b0; enable_p = 1'b1; enable_t = 1'b1; data_in = 4'd9;
    tick();
    chk("R2 initial clear", count, 0);
    clear_n = 1'b1;

    // R3: every value, every enable pair
    for (int v = 0; v < 16; v++) begin
      for (int e = 0; e < 4; e++) begin
        load_n = 1'b0; data_in = W'(v); enable_p = e[0]; enable_t = e[1];
        tick();
        chk("R3 load", count, v);
        chk("R7 carry after load", carry_out, (v == 15 && e[1]) ? 1 : 0);
      end
    end
    load_n = 1'b1;

    // R2: clear beats load and enables from every value
    for (int v = 0; v < 16; v++) begin
      load_n = 1'b0; data_in = W'(v); tick();
      clear_n = 1'b0; load_n = 1'b0; data_in = W'(15 - v);
      enable_p = 1'b1; enable_t = 1'b1;
      tick();
      chk("R2 clear priority", count, 0);
      clear_n = 1'b1;
    end
    load_n = 1'b1;

    // R5: hold for each inhibiting enable pair
    load_n = 1'b0; data_in = 4'd6; tick(); load_n = 1'b1;
    for (int e = 0; e < 3; e++) begin
      enable_p = e[0]; enable_t = e[1];
      tick(); tick();
      chk("R5 hold", count, 6);
    end

    // R7/R8: carry at all ones over enable sweeps, no edge between
    load_n = 1'b0; data_in = 4'hF; tick(); load_n = 1'b1;
    enable_p = 1'b0; enable_t = 1'b0; tick();
    for (int e = 0; e < 4; e++) begin
      enable_p = e[0]; enable_t = e[1];
      #1;
      chk("R8 carry vs enable_p", carry_out, e[1] ? 1 : 0);
    end
    enable_p = 1'b0; enable_t = 1'b1; #1;
    chk("R7 carry follows enable_t", carry_out, 1);
    enable_t = 1'b0; #1;
    chk("R7 carry drops with enable_t", carry_out, 0);

    // R4/R1/R6: count sweep from zero through wrap
    clear_n = 1'b0; tick(); clear_n = 1'b1;
    enable_p = 1'b1; enable_t = 1'b1;
    for (int i = 1; i <= 34; i++) begin
      tick();
      chk("R4 R1 step", count, i % 16);
      chk("R7 carry in sweep", carry_out, (i % 16 == 15) ? 1 : 0);
      if (i % 16 == 0) chk("R6 wrap carry low", carry_out, 0);
    end

    // R10: modulo-10 by decoding 9 onto clear_n
    clear_n = 1'b0; tick(); clear_n = 1'b1;
    exp = 0;
    for (int i = 0; i < 25; i++) begin
      clear_n = (count == 4'd9) ? 1'b0 : 1'b1;
      tick();
      exp = (exp + 1) % 10;
      chk("R10 truncated count", count, exp);
    end
    clear_n = 1'b1; enable_p = 1'b0; enable_t = 1'b0;

    // R9: 8-bit chain
    ch_clear_n = 1'b0; tick(); ch_clear_n = 1'b1;
    chk("R9 chain cleared", {hi_q, lo_q}, 0);
    ch_en = 1'b1;
    for (int i = 1; i <= 260; i++) begin
      tick();
      chk("R9 chain value", {hi_q, lo_q}, i % 256);
      chk("R9 chain carry", hi_c, (i % 256 == 255) ? 1 : 0);
    end
    ch_en = 1'b0; tick();
    chk("R9 chain hold", {hi_q, lo_q}, 260 % 256);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule